// File: doc/BRIEF.md
# Pad Pull-Device Reset Controller

This block holds a three-bit pull-control word and turns it into one weak-pull enable per I/O pad. Every pad belongs to a group: 5-V-only pads, special 3-V bus pads, timer-clock pads, or pads whose function never needs a pull. Each pad also has a direction. After reset, the group, the direction and the control word together decide whether the pad's pull device stays on or is dropped. While reset is in force, every pull device is held on, because no pad has a known function yet.

Two reset inputs reach the block. Power-on reset clears the control word and forces all pulls on asynchronously. Hard reset does the same, but only at a clock edge. This keeps the pulls from switching in the middle of a bus cycle that may still be running. Soft reset is not wired to this block, so a soft reset keeps both the control word and the pad configuration. Software programs the word through a plain write strobe and reads it back through a read strobe. The read data arrives one cycle after the strobe.

Top module: `pad_pull_ctrl`

## Requirements
- R1: While `por_n` is low, every bit of `pull_en` is 1 without waiting for a clock edge. The control word is cleared, so a read after release returns 0.
- R2: A rising clock edge with `hard_rst_n` low clears the control word. A write presented in that same cycle is lost.
- R3: After any rising edge at which `hard_rst_n` is low, every bit of `pull_en` is 1.
- R4: Control bit 0 is the global pull disable. Out of reset, a pad with group code 0 (5-V) has its pull enabled exactly when bit 0 is 0.
- R5: Control bit 1 is the special pull disable. Out of reset, a pad with group code 1 (special 3-V) has its pull enabled exactly when bit 1 is 0.
- R6: Control bit 2 is the follow bit, for pads with group code 2 (timer clock). When bit 2 is 0, the pull is enabled exactly when the pad is an input (`pin_dir_out` bit = 0). When bit 2 is 1, the pull is enabled exactly when bit 0 is 0.
- R7: Out of reset, a pad with group code 3 (no pull needed) has its pull disabled.
- R8: Bits 31..3 of the control word are reserved. They always read as 0, and writing them has no effect.
- R9: A read strobe at one edge puts the control word (as it stood before that edge) on `rd_data` after that edge. Without a strobe, `rd_data` is 0.
- R10: `pull_en` is registered. Each bit reflects the group, direction and control word sampled at the previous rising edge, so a write shows on the pads two edges after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| hard_rst_n | input | 1 | Hard reset, active low, synchronous to `clk` |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| pin_grp | input | 16 | Two-bit group code per pad, pad i at bits [2i+1:2i] |
| pin_dir_out | input | 8 | Pad direction, 1 = output |
| pull_en | output | 8 | Registered weak-pull enable per pad |

## Verification
The bench drops power-on reset between clock edges and checks that every pad's pull comes on before the next edge. A design that cleared only at the clock would leave pads floating for up to a cycle. It also presents a write in the same cycle as a hard reset: a design that let the write win would leave a pull disabled straight out of reset. The timer-clock pads are driven through both settings of the follow bit with mixed directions, which exposes a design that ignores direction or looks at the wrong disable bit. Writes with all ones then prove that the reserved bits stay zero.

// File: rtl/padpull_pkg.sv
// Package: shared types and the per-pad pull decision for the pad pull
// controller. Assumes group codes are fixed by the pad ring netlist.
package padpull_pkg;

    // Pad group codes: a pad's group decides which control bit governs it
    typedef enum logic [1:0] {
        GRP_5V     = 2'd0,
        GRP_SP3    = 2'd1,
        GRP_TCLK   = 2'd2,
        GRP_NOPULL = 2'd3
    } pad_grp_e;

    localparam int unsigned CTRL_BITS  = 3;
    localparam int unsigned BIT_GDIS   = 0;
    localparam int unsigned BIT_SDIS   = 1;
    localparam int unsigned BIT_FOLLOW = 2;

    // Control word as used by the pad logic (bit 2 .. bit 0)
    typedef struct packed {
        logic follow;
        logic sdis;
        logic gdis;
    } pull_ctrl_t;

    // Pull decision for one pad once reset has been released
    function automatic logic pull_wanted(pad_grp_e grp, logic is_out, pull_ctrl_t c);
        logic want;
        unique case (grp)
            GRP_5V:   want = !c.gdis;
            GRP_SP3:  want = !c.sdis;
            GRP_TCLK: want = c.follow ? !c.gdis : !is_out;
            default:  want = 1'b0;
        endcase
        return want;
    endfunction

endpackage

// File: rtl/padpull_regs.sv
// Module: control-word register with a registered read port.
// Assumes: por_n may assert at any time; its release and hard_rst_n are
// synchronous to clk. Reserved bits are masked at write and read as zero.
module padpull_regs
    import padpull_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hard_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output pull_ctrl_t        ctrl
);

    localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((1 << CTRL_BITS) - 1);

    logic [DATA_W-1:0] word_q;

    // Control word: async clear on power-on, sync clear on hard reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            word_q <= '0;
        end else if (!hard_rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data & IMPL_MASK;
        end
    end

    // Read port: one-cycle latency, zero when no strobe
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rd_data <= '0;
        end else if (!hard_rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? word_q : '0;
        end
    end

    assign ctrl = pull_ctrl_t'(word_q[CTRL_BITS-1:0]);

endmodule

// File: rtl/padpull_pin.sv
// Module: registered pull enable for one pad.
// Assumes the group and direction inputs are stable around the clock edge.
// Either reset forces the pull on; power-on does so without a clock.
module padpull_pin
    import padpull_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       hard_rst_n,
    input  pad_grp_e   grp,
    input  logic       is_out,
    input  pull_ctrl_t ctrl,
    output logic       pull_en
);

    // Pull flop: set by either reset, else follows the pad's decision
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pull_en <= 1'b1;
        end else if (!hard_rst_n) begin
            pull_en <= 1'b1;
        end else begin
            pull_en <= pull_wanted(grp, is_out, ctrl);
        end
    end

endmodule

// File: rtl/pad_pull_ctrl.sv
// Module: top of the pad pull controller. One control register and one
// pull flop per pad. Assumes soft reset is kept away from this block so
// that the pad configuration survives it.
module pad_pull_ctrl
    import padpull_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                hard_rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [2*N_PINS-1:0] pin_grp,
    input  logic [N_PINS-1:0]   pin_dir_out,
    output logic [N_PINS-1:0]   pull_en
);

    pull_ctrl_t ctrl_s;

    padpull_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .hard_rst_n (hard_rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .ctrl       (ctrl_s)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        padpull_pin u_pin (
            .clk        (clk),
            .por_n      (por_n),
            .hard_rst_n (hard_rst_n),
            .grp        (pad_grp_e'(pin_grp[2*i +: 2])),
            .is_out     (pin_dir_out[i]),
            .ctrl       (ctrl_s),
            .pull_en    (pull_en[i])
        );
    end

endmodule

// File: rtl/padpull_chk.sv
// Checker: temporal properties of the pad pull controller, bound to the top.
module padpull_chk
    import padpull_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                por_n,
    input logic                hard_rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [DATA_W-1:0]   rd_data,
    input logic [2*N_PINS-1:0] pin_grp,
    input logic [N_PINS-1:0]   pin_dir_out,
    input logic [N_PINS-1:0]   pull_en,
    input pull_ctrl_t          ctrl
);

    a_r2_hard_clears: assert property (@(posedge clk) disable iff (!por_n)
        (!hard_rst_n && wr_en) |=> (ctrl == '0));

    a_r3_pulls_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        !hard_rst_n |=> (&pull_en));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[DATA_W-1:CTRL_BITS] == '0);

    a_r9_read_latency: assert property (@(posedge clk) disable iff (!por_n)
        (hard_rst_n && rd_en) |=> (rd_data[CTRL_BITS-1:0] == $past(ctrl)));

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin_chk
        a_r4_5v_follows_gdis: assert property (@(posedge clk) disable iff (!por_n)
            (hard_rst_n && pin_grp[2*i +: 2] == GRP_5V) |=> (pull_en[i] == !$past(ctrl.gdis)));

        a_r5_sp3_follows_sdis: assert property (@(posedge clk) disable iff (!por_n)
            (hard_rst_n && pin_grp[2*i +: 2] == GRP_SP3) |=> (pull_en[i] == !$past(ctrl.sdis)));

        a_r6_tclk_input_pull: assert property (@(posedge clk) disable iff (!por_n)
            (hard_rst_n && pin_grp[2*i +: 2] == GRP_TCLK && !ctrl.follow && !pin_dir_out[i])
            |=> pull_en[i]);

        a_r7_nopull_off: assert property (@(posedge clk) disable iff (!por_n)
            (hard_rst_n && pin_grp[2*i +: 2] == GRP_NOPULL) |=> !pull_en[i]);
    end

endmodule

bind pad_pull_ctrl padpull_chk #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .hard_rst_n  (hard_rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .pin_grp     (pin_grp),
    .pin_dir_out (pin_dir_out),
    .pull_en     (pull_en),
    .ctrl        (ctrl_s)
);

// File: tb/pad_pull_ctrl_test.sv
`timescale 1ns/1ps
module pad_pull_ctrl_test;

    localparam int NP = 8;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            hard_rst_n = 1'b1;
    logic            wr_en = 1'b0;
    logic [DW-1:0]   wr_data = '0;
    logic            rd_en = 1'b0;
    logic [DW-1:0]   rd_data;
    logic [2*NP-1:0] pin_grp = '0;
    logic [NP-1:0]   pin_dir_out = '0;
    logic [NP-1:0]   pull_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0]    m_ctrl = '0;
    logic [NP-1:0] m_pull = '1;
    logic [DW-1:0] m_rd = '0;

    always #2 clk = ~clk;

    pad_pull_ctrl #(.N_PINS(NP), .DATA_W(DW)) uut (
        .clk(clk), .por_n(por_n), .hard_rst_n(hard_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_grp(pin_grp), .pin_dir_out(pin_dir_out), .pull_en(pull_en)
    );

    // Expected pull for one pad from the requirement text (R4..R7)
    function automatic logic exp_pull(logic [1:0] g, logic is_out, logic [2:0] c);
        case (g)
            2'd0:    return !c[0];
            2'd1:    return !c[1];
            2'd2:    return c[2] ? !c[0] : !is_out;
            default: return 1'b0;
        endcase
    endfunction

    // One rising edge, with the model advanced the same way
    task automatic tick;
        @(posedge clk);
        if (!por_n || !hard_rst_n) begin
            m_pull = '1; m_ctrl = '0; m_rd = '0;
        end else begin
            for (int i = 0; i < NP; i++)
                m_pull[i] = exp_pull(pin_grp[2*i +: 2], pin_dir_out[i], m_ctrl);
            m_rd = rd_en ? {29'd0, m_ctrl} : '0;
            if (wr_en) m_ctrl = wr_data[2:0];
        end
        @(negedge clk);
    endtask

    task automatic check_pull(string tag);
        checks++;
        if (pull_en !== m_pull) begin
            errors++;
            $display("FAIL %s pull_en act=%h exp=%h", tag, pull_en, m_pull);
        end
    endtask

    task automatic check_rd(string tag);
        checks++;
        if (rd_data !== m_rd) begin
            errors++;
            $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, m_rd);
        end
    endtask

    task automatic write(logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    // Read back the word; result is on rd_data after this returns
    task automatic read_check(string tag);
        rd_en = 1'b1; tick(); rd_en = 1'b0; check_rd(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: power-on held from the start
        tick(); tick();
        check_pull("R1");
        check_rd("R1");
        por_n = 1'b1;

        // R3: hard reset held for two edges
        hard_rst_n = 1'b0;
        tick(); check_pull("R3");
        tick(); check_pull("R3");
        hard_rst_n = 1'b1;

        // Pads: groups 0,1,2,3 repeated, odd pads outputs
        pin_grp = 16'b11_10_01_00_11_10_01_00;
        pin_dir_out = 8'b1010_1010;
        tick(); check_pull("R7");

        // R4: global disable set
        write(32'h1); tick(); check_pull("R4");
        // R5: special disable only
        write(32'h2); tick(); check_pull("R5");
        // R6: follow=0, timer pads track direction
        write(32'h0); tick(); check_pull("R6");
        // R6: follow=1 with global disable
        write(32'h5); tick(); check_pull("R6");
        // R6: follow=1, global enabled
        write(32'h4); tick(); check_pull("R6");

        // R8: reserved bits ignored
        write(32'hFFFF_FFFF);
        read_check("R8");
        tick(); check_pull("R10");

        // R9: no strobe gives zero
        tick(); check_rd("R9");

        // R2: write in the same cycle as hard reset loses
        hard_rst_n = 1'b0; wr_en = 1'b1; wr_data = 32'h7;
        tick(); wr_en = 1'b0; hard_rst_n = 1'b1;
        check_pull("R2");
        read_check("R2");
        tick(); check_pull("R2");

        // R1: power-on dropped between edges
        write(32'h3); tick();
        #1 por_n = 1'b0;
        #0.5;
        m_pull = '1; m_ctrl = '0; m_rd = '0;
        check_pull("R1");
        @(negedge clk);
        tick();
        por_n = 1'b1;
        read_check("R1");

        // R10: random stimulus
        for (int n = 0; n < 400; n++) begin
            wr_en = ($urandom % 4) == 0;
            wr_data = $urandom;
            rd_en = $urandom % 2;
            pin_grp = 16'($urandom);
            pin_dir_out = 8'($urandom);
            hard_rst_n = ($urandom % 40) != 0;
            tick();
            check_pull("R10");
            check_rd("R9");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule